// File: doc/BRIEF.md
# Open-Page Bank Mapping and Row Close

This block sits in front of a DRAM command scheduler. It takes cache-line addresses and does two jobs. First, it splits each address into a bank number, a row number and a position within a small group of lines. Second, it tracks the row that is currently open in every bank. Runs of four consecutive cache lines stay in one bank, and the next run moves to the next bank. This keeps some row locality while still spreading traffic over all banks.

Each access is classed against the state of its bank. The four classes are:
- a hit on the open row;
- an activate of a closed bank;
- a conflict, which needs a precharge before the new row can open;
- an access that arrives while a precharge is still outstanding.

Rows do not stay open for ever. A per-bank countdown closes an idle row after a fixed number of clock cycles. An access that carries the end-of-burst flag closes the row as soon as it is served. Each precharge is raised as a per-bank request that stays up until the command logic acknowledges it.

Top module: `obp_rowclose_top`

## Requirements
- R1: The input is a line address with the byte offset already removed. Bits [1:0] give the lane, which is the position within a group of four lines. Bits [4:2] give the bank. Bits [25:5] give the row. Four consecutive lines therefore share a bank, and line 4·k+4 maps to the bank after that of line 4·k.
- R2: One clock after an edge with `acc_vld` high, `map_vld` is high and `map_bank`, `map_row` and `map_lane` carry the decode of that access. After an edge with `acc_vld` low, `map_vld` is low.
- R3: `map_cls` encodes the access class as follows. 0 is a hit on the open row. 1 is a closed bank, and the row is activated. 2 is a conflict: another row is open, a precharge is requested, and the new row opens after the acknowledge. 3 is an access to a bank whose precharge is still outstanding; its row opens once that precharge is acknowledged.
- R4: A conflict raises `pre_req` of that bank on the same edge that registers the class. After the acknowledge, the bank holds the new row, so the next access to that row is a hit.
- R5: An open bank with no access raises its `pre_req` on the CLOSE_CYC-th edge after the edge that activated the row or last hit it. One edge earlier, the request is still low. A hit restarts this count. After the acknowledge, the bank is closed.
- R6: An access with `burst_end` high raises `pre_req` of its bank on the next edge, whatever its class. After the acknowledge, the bank is closed.
- R7: A raised `pre_req` bit stays high until an edge with the matching `pre_ack` bit high, and is low after that edge.
- R8: A `pre_ack` bit for a bank with no outstanding request has no effect: the open row and its class stay unchanged.
- R9: Synchronous reset clears every `pre_req` bit and `map_vld`, and leaves every bank closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access present this cycle |
| acc_addr | input | 26 | Cache-line address (byte offset removed) |
| burst_end | input | 1 | This access ends a prefetch burst; close its row afterwards |
| pre_ack | input | 8 | Per-bank precharge acknowledge |
| map_vld | output | 1 | Registered decode valid |
| map_bank | output | 3 | Decoded bank |
| map_row | output | 21 | Decoded row |
| map_lane | output | 2 | Line position within its group |
| map_cls | output | 2 | Access class (hit, activate, conflict, wait) |
| pre_req | output | 8 | Per-bank precharge request, held until acknowledged |

## Verification
A vector table first steps through lanes 0 to 3 of one group and then line index 4. This separates "same bank within a group" from "next bank after a group". The same table revisits a bank with the same row, a different row, and a row pending behind an outstanding precharge, which tells apart all four class codes. Burst-end accesses on a hit and on a closed bank show that the flag closes the row whatever the class. Directed runs then count idle edges to the exact cycle of the timeout, both with and without a restarting hit. They also hold a request without acknowledge, send a spurious acknowledge, and reset while a request is pending.

// File: rtl/obp_pkg.sv
`timescale 1ns/1ps
package obp_pkg;
  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_EMPTY    = 2'd1,
    CLS_CONFLICT = 2'd2,
    CLS_WAIT     = 2'd3
  } cls_t;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_PRE_CLOSE,
    BK_PRE_SWITCH
  } bank_st_t;
endpackage

// File: rtl/obp_addr_map.sv
`timescale 1ns/1ps
module obp_addr_map #(
  parameter int LINE_AW   = 26,
  parameter int GRP_BITS  = 2,
  parameter int BANK_BITS = 3,
  localparam int ROW_LSB  = GRP_BITS + BANK_BITS,
  localparam int ROW_W    = LINE_AW - ROW_LSB
) (
  input  logic [LINE_AW-1:0]   line_addr,
  output logic [BANK_BITS-1:0] bank,
  output logic [ROW_W-1:0]     row,
  output logic [GRP_BITS-1:0]  lane
);
  // Low bits walk the lines of one group; the bank field sits just above them.
  always_comb begin
    lane = line_addr[GRP_BITS-1:0];
    bank = line_addr[GRP_BITS +: BANK_BITS];
    row  = line_addr[LINE_AW-1:ROW_LSB];
  end
endmodule

// File: rtl/obp_bank_ctl.sv
`timescale 1ns/1ps
module obp_bank_ctl
  import obp_pkg::*;
#(
  parameter int ROW_W     = 21,
  parameter int CLOSE_CYC = 40,
  localparam int TMR_W    = $clog2(CLOSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             be,
  input  logic [ROW_W-1:0] row_in,
  input  logic             ack,
  output cls_t             cls_c,
  output logic             pre_req
);
  localparam logic [TMR_W-1:0] LOAD = TMR_W'(CLOSE_CYC - 1);

  bank_st_t         st, st_n;
  logic [ROW_W-1:0] open_row, row_n;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic             req_n;
  logic             same_row;

  assign same_row = (row_in == open_row);

  always_comb begin
    st_n  = st;
    row_n = open_row;
    tmr_n = tmr;
    req_n = pre_req;
    cls_c = CLS_EMPTY;
    case (st)
      BK_IDLE: begin
        cls_c = CLS_EMPTY;
        if (sel) begin
          row_n = row_in;
          if (be) begin
            st_n  = BK_PRE_CLOSE;
            req_n = 1'b1;
          end else begin
            st_n  = BK_OPEN;
            tmr_n = LOAD;
          end
        end
      end
      BK_OPEN: begin
        cls_c = same_row ? CLS_HIT : CLS_CONFLICT;
        if (sel) begin
          if (be) begin
            st_n  = BK_PRE_CLOSE;
            req_n = 1'b1;
          end else if (same_row) begin
            tmr_n = LOAD;
          end else begin
            st_n  = BK_PRE_SWITCH;
            req_n = 1'b1;
            row_n = row_in;
          end
        end else if (tmr == '0) begin
          st_n  = BK_PRE_CLOSE;
          req_n = 1'b1;
        end else begin
          tmr_n = tmr - TMR_W'(1);
        end
      end
      default: begin
        cls_c = CLS_WAIT;
        if (sel) begin
          row_n = row_in;
          if (be) begin
            st_n  = BK_PRE_CLOSE;
            req_n = 1'b1;
          end else if (ack) begin
            st_n  = BK_OPEN;
            tmr_n = LOAD;
            req_n = 1'b0;
          end else begin
            st_n  = BK_PRE_SWITCH;
          end
        end else if (ack) begin
          req_n = 1'b0;
          if (st == BK_PRE_SWITCH) begin
            st_n  = BK_OPEN;
            tmr_n = LOAD;
          end else begin
            st_n  = BK_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BK_IDLE;
      open_row <= '0;
      tmr      <= '0;
      pre_req  <= 1'b0;
    end else begin
      st       <= st_n;
      open_row <= row_n;
      tmr      <= tmr_n;
      pre_req  <= req_n;
    end
  end
endmodule

// File: rtl/obp_rowclose_top.sv
`timescale 1ns/1ps
module obp_rowclose_top
  import obp_pkg::*;
#(
  parameter int LINE_AW   = 26,
  parameter int GRP_BITS  = 2,
  parameter int BANK_BITS = 3,
  parameter int CLOSE_CYC = 40,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int ROW_W    = LINE_AW - GRP_BITS - BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_vld,
  input  logic [LINE_AW-1:0]   acc_addr,
  input  logic                 burst_end,
  input  logic [NBANK-1:0]     pre_ack,
  output logic                 map_vld,
  output logic [BANK_BITS-1:0] map_bank,
  output logic [ROW_W-1:0]     map_row,
  output logic [GRP_BITS-1:0]  map_lane,
  output logic [1:0]           map_cls,
  output logic [NBANK-1:0]     pre_req
);
  logic [BANK_BITS-1:0] dec_bank;
  logic [ROW_W-1:0]     dec_row;
  logic [GRP_BITS-1:0]  dec_lane;
  cls_t                 bank_cls [NBANK];
  cls_t                 sel_cls;

  obp_addr_map #(
    .LINE_AW  (LINE_AW),
    .GRP_BITS (GRP_BITS),
    .BANK_BITS(BANK_BITS)
  ) u_map (
    .line_addr(acc_addr),
    .bank     (dec_bank),
    .row      (dec_row),
    .lane     (dec_lane)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_sel;
    assign hit_sel = acc_vld && (dec_bank == BANK_BITS'(b));
    obp_bank_ctl #(
      .ROW_W    (ROW_W),
      .CLOSE_CYC(CLOSE_CYC)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .sel    (hit_sel),
      .be     (burst_end),
      .row_in (dec_row),
      .ack    (pre_ack[b]),
      .cls_c  (bank_cls[b]),
      .pre_req(pre_req[b])
    );
  end

  assign sel_cls = bank_cls[dec_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      map_vld  <= 1'b0;
      map_bank <= '0;
      map_row  <= '0;
      map_lane <= '0;
      map_cls  <= '0;
    end else begin
      map_vld <= acc_vld;
      if (acc_vld) begin
        map_bank <= dec_bank;
        map_row  <= dec_row;
        map_lane <= dec_lane;
        map_cls  <= sel_cls;
      end
    end
  end
endmodule

// File: rtl/obp_rowclose_chk.sv
`timescale 1ns/1ps
module obp_rowclose_chk #(
  parameter int LINE_AW   = 26,
  parameter int GRP_BITS  = 2,
  parameter int BANK_BITS = 3,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int ROW_LSB  = GRP_BITS + BANK_BITS,
  localparam int ROW_W    = LINE_AW - ROW_LSB
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 acc_vld,
  input logic [LINE_AW-1:0]   acc_addr,
  input logic                 burst_end,
  input logic [NBANK-1:0]     pre_ack,
  input logic                 map_vld,
  input logic [BANK_BITS-1:0] map_bank,
  input logic [ROW_W-1:0]     map_row,
  input logic [GRP_BITS-1:0]  map_lane,
  input logic [NBANK-1:0]     pre_req
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (map_vld == $past(acc_vld)));

  // R1
  decode_chk: assert property (@(posedge clk) disable iff (rst)
    map_vld |-> (map_bank == $past(acc_addr[GRP_BITS +: BANK_BITS]) &&
                 map_row  == $past(acc_addr[LINE_AW-1:ROW_LSB]) &&
                 map_lane == $past(acc_addr[GRP_BITS-1:0])));

  // R6
  burst_close_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && burst_end) |=> pre_req[$past(acc_addr[GRP_BITS +: BANK_BITS])]);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pre_req == '0 && !map_vld));

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_req[b] && !pre_ack[b]) |=> pre_req[b]);
  end
endmodule

bind obp_rowclose_top obp_rowclose_chk #(
  .LINE_AW  (LINE_AW),
  .GRP_BITS (GRP_BITS),
  .BANK_BITS(BANK_BITS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_vld  (acc_vld),
  .acc_addr (acc_addr),
  .burst_end(burst_end),
  .pre_ack  (pre_ack),
  .map_vld  (map_vld),
  .map_bank (map_bank),
  .map_row  (map_row),
  .map_lane (map_lane),
  .pre_req  (pre_req)
);

// File: tb/sim_obp_rowclose_top.sv
`timescale 1ns/1ps
module sim_obp_rowclose_top;
  localparam int CLOSE = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 1'b0;
  logic [25:0] acc_addr = '0;
  logic        burst_end = 1'b0;
  logic [7:0]  pre_ack = '0;
  logic        map_vld;
  logic [2:0]  map_bank;
  logic [20:0] map_row;
  logic [1:0]  map_lane;
  logic [1:0]  map_cls;
  logic [7:0]  pre_req;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  obp_rowclose_top #(.CLOSE_CYC(CLOSE)) u0 (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .burst_end(burst_end), .pre_ack(pre_ack), .map_vld(map_vld),
    .map_bank(map_bank), .map_row(map_row), .map_lane(map_lane),
    .map_cls(map_cls), .pre_req(pre_req)
  );

  typedef struct packed {
    logic [25:0] addr;
    logic        be;
    logic [7:0]  ack;
    logic [2:0]  bank;
    logic [1:0]  cls;
    logic [7:0]  pre;
  } vec_t;

  // classes: 0 hit, 1 activate, 2 conflict, 3 wait
  localparam vec_t VECS [11] = '{
    '{26'h00000A0, 1'b0, 8'h00, 3'd0, 2'd1, 8'h00},
    '{26'h00000A1, 1'b0, 8'h00, 3'd0, 2'd0, 8'h00},
    '{26'h00000A3, 1'b0, 8'h00, 3'd0, 2'd0, 8'h00},
    '{26'h00000A4, 1'b0, 8'h00, 3'd1, 2'd1, 8'h00},
    '{26'h00000E0, 1'b0, 8'h00, 3'd0, 2'd2, 8'h01},
    '{26'h00000E1, 1'b0, 8'h01, 3'd0, 2'd3, 8'h01},
    '{26'h00000E2, 1'b0, 8'h00, 3'd0, 2'd0, 8'h00},
    '{26'h000003C, 1'b1, 8'h80, 3'd7, 2'd1, 8'h80},
    '{26'h000003D, 1'b0, 8'h00, 3'd7, 2'd1, 8'h00},
    '{26'h3FFFFFF, 1'b0, 8'h80, 3'd7, 2'd2, 8'h80},
    '{26'h00000E0, 1'b1, 8'h01, 3'd0, 2'd0, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic [25:0] a, input logic be);
    @(negedge clk);
    acc_vld = 1'b1; acc_addr = a; burst_end = be;
    @(negedge clk);
    acc_vld = 1'b0; burst_end = 1'b0;
  endtask

  task automatic ack(input logic [7:0] m);
    @(negedge clk) pre_ack = m;
    @(negedge clk) pre_ack = '0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk(pre_req == 8'h00, "R9 pre_req after reset", 32'(pre_req), 0);
    chk(map_vld == 1'b0, "R9 map_vld after reset", 32'(map_vld), 0);

    foreach (VECS[i]) begin
      access(VECS[i].addr, VECS[i].be);
      chk(map_vld == 1'b1, "R2 map_vld after access", 32'(map_vld), 1);
      chk(map_bank == VECS[i].bank, "R1 bank", 32'(map_bank), 32'(VECS[i].bank));
      chk(map_row == VECS[i].addr[25:5], "R1 row", 32'(map_row),
          32'(VECS[i].addr[25:5]));
      chk(map_lane == VECS[i].addr[1:0], "R1 lane", 32'(map_lane),
          32'(VECS[i].addr[1:0]));
      chk(map_cls == VECS[i].cls, "R3 class", 32'(map_cls), 32'(VECS[i].cls));
      chk(pre_req == VECS[i].pre, "R4 R6 pre_req", 32'(pre_req), 32'(VECS[i].pre));
      ack(VECS[i].ack);
      chk((pre_req & VECS[i].ack) == 8'h00, "R7 cleared by ack",
          32'(pre_req), 32'(pre_req & ~VECS[i].ack));
    end

    // R2 no access -> map_vld low
    chk(map_vld == 1'b0, "R2 idle map_vld", 32'(map_vld), 0);

    // R5 exact timeout without hits: bank2 row9
    do_reset();
    access({21'd9, 3'd2, 2'd0}, 1'b0);
    repeat (CLOSE - 1) @(negedge clk);
    chk(pre_req[2] == 1'b0, "R5 one edge before timeout", 32'(pre_req), 0);
    @(negedge clk);
    chk(pre_req[2] == 1'b1, "R5 timeout edge", 32'(pre_req), 32'h04);

    // R5 hit restarts count
    do_reset();
    access({21'd9, 3'd2, 2'd0}, 1'b0);
    repeat (15) @(negedge clk);
    access({21'd9, 3'd2, 2'd1}, 1'b0);
    chk(map_cls == 2'd0, "R5 hit before timeout", 32'(map_cls), 0);
    repeat (CLOSE - 1) @(negedge clk);
    chk(pre_req[2] == 1'b0, "R5 restarted count not yet expired", 32'(pre_req), 0);
    @(negedge clk);
    chk(pre_req[2] == 1'b1, "R5 restarted count expires", 32'(pre_req), 32'h04);

    // R7 held without ack
    repeat (10) @(negedge clk);
    chk(pre_req == 8'h04, "R7 held while unacknowledged", 32'(pre_req), 32'h04);
    ack(8'h04);
    chk(pre_req == 8'h00, "R7 cleared after ack", 32'(pre_req), 0);
    access({21'd9, 3'd2, 2'd0}, 1'b0);
    chk(map_cls == 2'd1, "R5 bank closed after timeout", 32'(map_cls), 1);

    // R8 spurious ack ignored
    access({21'd3, 3'd5, 2'd0}, 1'b0);
    chk(map_cls == 2'd1, "R8 activate bank5", 32'(map_cls), 1);
    ack(8'h20);
    chk(pre_req[5] == 1'b0, "R8 no request after spurious ack", 32'(pre_req), 0);
    access({21'd3, 3'd5, 2'd2}, 1'b0);
    chk(map_cls == 2'd0, "R8 row still open", 32'(map_cls), 0);

    // R9 reset with a pending request
    access({21'd4, 3'd5, 2'd0}, 1'b0);
    chk(pre_req[5] == 1'b1, "R4 conflict raises request", 32'(pre_req), 32'h20);
    do_reset();
    chk(pre_req == 8'h00, "R9 reset clears request", 32'(pre_req), 0);
    chk(map_vld == 1'b0, "R9 reset clears valid", 32'(map_vld), 0);
    access({21'd3, 3'd5, 2'd0}, 1'b0);
    chk(map_cls == 2'd1, "R9 bank closed after reset", 32'(map_cls), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule